// File: doc/BRIEF.md
# Soft Reset and Clock Gate Controller

This block holds the reset-and-gating slice of a peripheral's control word. Software can drive a soft reset into the downstream functional logic and gate that logic's clock. The word is reachable through three write ports. A plain write replaces the whole word. A set alias turns on only the bits written as 1. A clear alias turns off only the bits written as 1. The current word is always visible on the read port, so software can poll either bit.

When the soft-reset bit is raised, the block holds the functional logic in synchronous reset. The clock keeps running for a fixed number of cycles so that the reset reaches every flop. The block then sets the gate bit by itself, which stops the functional clock enable. Software watches for the gate bit, drops soft reset, and then clears the gate to restart the clock. The remaining bits of the word form a configuration field. That field is forced to its default value for as long as soft reset is held.

Top module: `srcg_ctrl`

## Requirements
- R1: After rst_n is released, rd_data reads {0,0,CFG_DEFAULT}, func_clk_en is 1 and func_srst is 0.
- R2: A plain write (wr_en) loads all DATA_W bits, and rd_data returns the new word on the following cycle. Bit DATA_W-1 is soft reset, bit DATA_W-2 is the gate, and bits DATA_W-3:0 are the configuration field, which also drives cfg_out.
- R3: A set-alias write (set_en) turns on each bit whose set_data bit is 1 and leaves every other bit unchanged.
- R4: A clear-alias write (clr_en) turns off each bit whose clr_data bit is 1 and leaves every other bit unchanged.
- R5: Writes in the same cycle take effect in a fixed order: the plain write first, then the set alias, then the clear alias. A bit that is both set and cleared in one cycle ends up 0.
- R6: func_srst equals the soft-reset bit. It rises and falls on the clock edge at which the write that changes the bit is taken.
- R7: While soft reset stays at 1, the gate bit is set automatically GATE_DELAY edges after the soft-reset bit first reads 1. It still reads 0 after GATE_DELAY-1 edges. If soft reset is released before that point, the gate is not set.
- R8: func_clk_en is the inverse of the gate bit. With soft reset at 0, software may set or clear the gate bit directly.
- R9: While the soft-reset bit reads 1, any write that would clear the gate bit has no effect. This includes the same write that releases soft reset.
- R10: While the soft-reset bit reads 1, the configuration field is forced to CFG_DEFAULT on every edge and writes to it are ignored.
- R11: Once set, the gate bit stays 1 after soft reset is released, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Plain write strobe |
| wr_data | input | DATA_W | Plain write data |
| set_en | input | 1 | Set-alias write strobe |
| set_data | input | DATA_W | Mask of bits to turn on |
| clr_en | input | 1 | Clear-alias write strobe |
| clr_data | input | DATA_W | Mask of bits to turn off |
| rd_data | output | DATA_W | Current control word |
| cfg_out | output | DATA_W-2 | Configuration field for downstream logic |
| func_clk_en | output | 1 | Functional clock enable (1 = running) |
| func_srst | output | 1 | Synchronous reset for downstream logic |

## Verification
The bench builds the block with DATA_W=16, a nonzero CFG_DEFAULT of 14'h1A5 and GATE_DELAY=4. The nonzero default makes the forced configuration value distinguishable from a cleared field. The four-cycle delay lets the bench check the gate edge by edge, both just before and exactly at the automatic assertion. The small width keeps the soft-reset and gate bit positions at 15 and 14, so set, clear and same-cycle collisions can be aimed at single bits.

// File: rtl/srcg_ctrl.sv
module srcg_ctrl #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-3:0] CFG_DEFAULT = '0,
  parameter int GATE_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              set_en,
  input  logic [DATA_W-1:0] set_data,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-3:0] cfg_out,
  output logic              func_clk_en,
  output logic              func_srst
);
  localparam int SRST_BIT = DATA_W - 1;
  localparam int GATE_BIT = DATA_W - 2;
  localparam int CFG_W    = DATA_W - 2;
  localparam int CNT_W    = $clog2(GATE_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GATE_DELAY - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(GATE_DELAY);

  logic             srst_q, gate_q;
  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DATA_W-1:0] nxt;
  logic             drained;

  assign rd_data     = {srst_q, gate_q, cfg_q};
  assign cfg_out     = cfg_q;
  assign func_clk_en = ~gate_q;
  assign func_srst   = srst_q;
  assign drained     = (cnt_q == CNT_LAST);

  always_comb begin
    nxt = wr_en ? wr_data : rd_data;
    if (set_en) nxt = nxt | set_data;
    if (clr_en) nxt = nxt & ~clr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      gate_q <= 1'b0;
      cfg_q  <= CFG_DEFAULT;
      cnt_q  <= '0;
    end else begin
      srst_q <= nxt[SRST_BIT];
      if (srst_q) begin
        cfg_q  <= CFG_DEFAULT;
        gate_q <= gate_q | nxt[GATE_BIT] | drained;
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end else begin
        cfg_q  <= nxt[CFG_W-1:0];
        gate_q <= nxt[GATE_BIT];
        cnt_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/srcg_ctrl_chk.sv
module srcg_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-3:0] CFG_DEFAULT = '0,
  parameter int GATE_DELAY = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              set_en,
  input logic [DATA_W-1:0] set_data,
  input logic              clr_en,
  input logic [DATA_W-1:0] clr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-3:0] cfg_out,
  input logic              func_clk_en,
  input logic              func_srst
);
  localparam int SB = DATA_W - 1;
  localparam int GB = DATA_W - 2;
  localparam int RW = $clog2(GATE_DELAY + 1);

  logic [RW-1:0] run;
  logic gate_touch;
  assign gate_touch = (set_en && set_data[GB]) || (wr_en && wr_data[GB]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (!func_srst) run <= '0;
    else if (run != RW'(GATE_DELAY)) run <= run + 1'b1;
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!func_srst && set_en && clr_en && set_data[0] && clr_data[0]) |=> !cfg_out[0]); // R5
  AST_SRST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_data[SB]) |=> !func_srst); // R6
  AST_SRST_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_data[SB] && !(clr_en && clr_data[SB])) |=> func_srst); // R6
  AST_AUTO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (func_srst && run == RW'(GATE_DELAY - 1)) |=> !func_clk_en); // R7
  AST_NO_EARLY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (func_srst && func_clk_en && run < RW'(GATE_DELAY - 1) && !gate_touch) |=> func_clk_en); // R7
  AST_GATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (func_srst && !func_clk_en) |=> !func_clk_en); // R9
  AST_CFG_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    func_srst |=> (cfg_out == CFG_DEFAULT)); // R10
  AST_GATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!func_clk_en && !(clr_en && clr_data[GB]) && !(wr_en && !wr_data[GB])) |=> !func_clk_en); // R11
  AST_READ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[GB] != func_clk_en)); // R8
endmodule

bind srcg_ctrl srcg_ctrl_chk #(
  .DATA_W(DATA_W), .CFG_DEFAULT(CFG_DEFAULT), .GATE_DELAY(GATE_DELAY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .set_en(set_en), .set_data(set_data), .clr_en(clr_en), .clr_data(clr_data),
  .rd_data(rd_data), .cfg_out(cfg_out), .func_clk_en(func_clk_en), .func_srst(func_srst)
);

// File: tb/srcg_ctrl_test.sv
module srcg_ctrl_test;
  localparam int W = 16;
  localparam logic [W-3:0] DEF = 14'h1A5;
  localparam logic [W-1:0] S = 16'h8000;
  localparam logic [W-1:0] G = 16'h4000;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, set_en = 0, clr_en = 0;
  logic [W-1:0] wr_data = '0, set_data = '0, clr_data = '0;
  logic [W-1:0] rd_data;
  logic [W-3:0] cfg_out;
  logic func_clk_en, func_srst;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  srcg_ctrl #(.DATA_W(W), .CFG_DEFAULT(DEF), .GATE_DELAY(4)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .set_en(set_en), .set_data(set_data), .clr_en(clr_en), .clr_data(clr_data),
    .rd_data(rd_data), .cfg_out(cfg_out), .func_clk_en(func_clk_en), .func_srst(func_srst));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic [W-1:0] wd, input logic se,
                    input logic [W-1:0] sd, input logic ce, input logic [W-1:0] cd);
    @(negedge clk);
    wr_en = we; wr_data = wd; set_en = se; set_data = sd; clr_en = ce; clr_data = cd;
    @(posedge clk); #1;
    wr_en = 0; set_en = 0; clr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, {2'b00, DEF});
    chk("R1 clk_en", func_clk_en, 1);
    chk("R1 srst", func_srst, 0);
  endtask

  task automatic t_access;
    op(1, 16'h0123, 0, '0, 0, '0);
    chk("R2 plain", rd_data, 16'h0123);
    chk("R2 cfg_out", cfg_out, 14'h0123);
    op(0, '0, 1, 16'h0300, 0, '0);
    chk("R3 set", rd_data, 16'h0323);
    op(0, '0, 0, '0, 1, 16'h0021);
    chk("R4 clear", rd_data, 16'h0302);
    op(0, '0, 1, 16'h000C, 1, 16'h0008);
    chk("R5 clear wins", rd_data, 16'h0306);
    op(1, 16'h0000, 1, 16'h0011, 1, 16'h0010);
    chk("R5 order", rd_data, 16'h0001);
  endtask

  task automatic t_sw_gate;
    op(0, '0, 1, G, 0, '0);
    chk("R8 gated", func_clk_en, 0);
    chk("R8 srst low", func_srst, 0);
    op(0, '0, 0, '0, 1, G);
    chk("R8 ungated", func_clk_en, 1);
    chk("R8 read", rd_data, 16'h0001);
  endtask

  task automatic t_early_release;
    op(0, '0, 1, S, 0, '0);
    op(0, '0, 0, '0, 1, S);
    chk("R6 released", func_srst, 0);
    idle(6);
    chk("R7 no gate on short reset", rd_data[14], 0);
    chk("R7 clock still on", func_clk_en, 1);
  endtask

  task automatic t_full_cycle;
    op(1, 16'h0055, 0, '0, 0, '0);
    op(0, '0, 1, S, 0, '0);
    chk("R6 srst out", func_srst, 1);
    chk("R6 srst bit", rd_data[15], 1);
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); #1;
      chk($sformatf("R7 gate after %0d edges", k), rd_data[14], (k >= 4));
      chk("R8 clk_en tracks gate", func_clk_en, (k < 4));
      chk("R10 cfg forced", cfg_out, DEF);
    end
    op(1, S | G | 16'h0077, 0, '0, 0, '0);
    chk("R10 cfg write ignored", cfg_out, DEF);
    op(0, '0, 0, '0, 1, G);
    chk("R9 gate clear ignored", rd_data[14], 1);
    op(0, '0, 0, '0, 1, S | G);
    chk("R6 release", func_srst, 0);
    chk("R9 joint clear ignored", rd_data[14], 1);
    idle(3);
    chk("R11 gate sticky", func_clk_en, 0);
    op(0, '0, 0, '0, 1, G);
    chk("R11 gate cleared", func_clk_en, 1);
    chk("R11 word", rd_data, {2'b00, DEF});
    op(1, 16'h0012, 0, '0, 0, '0);
    chk("R10 cfg writable again", cfg_out, 14'h0012);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset();
    t_access();
    t_sw_gate();
    t_early_release();
    t_full_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule